// File: doc/BRIEF.md
# Seconds-Countdown Watchdog Timer

This block is a software-programmed watchdog. Three 8-bit registers sit behind a simple register port: a timeout register, a control register and a status register. Writing a nonzero value to the timeout register loads a down counter and arms it. Writing it again while the counter is running reloads it, which is the keepalive. Writing zero disarms the watchdog. Reading the timeout register returns the time that is left, not the value last written.

A prescaler turns the free-running input clock into one step per second, or one step per minute when the control register selects minutes. The counter decrements only on those steps. When the count passes from 1 to 0, the block latches an expiry flag in the status register. If the control register allows it, the block also drives its active-low reset output low for a fixed number of clock cycles. The counter then stays at zero until software writes it again.

Top module: `wdt_timer`

## Requirements
- R1: After reset the remaining count, the control register and the status register all read 0, and `wdt_rst_n` is high.
- R2: Register select 0 is the timeout register. A write of a nonzero value N makes it read N on the next cycle. The count then drops by one every CLKS_PER_SEC cycles, measured from the write edge, while control bit 3 is 0.
- R3: Writing 0 to the timeout register stops the countdown. The count stays 0, the status flag is not set and `wdt_rst_n` stays high.
- R4: Rewriting a nonzero value while the count is running reloads it. The prescaler also restarts, so the next full step of CLKS_PER_SEC cycles begins at that write.
- R5: On the step where the count goes from 1 to 0, status bit 4 (select 2) becomes 1. The count then holds at 0 with no further writes.
- R6: When control bit 1 (select 1) is 1 at expiry, `wdt_rst_n` is low for exactly PULSE_CYCLES cycles, starting in the cycle after the expiry edge. When the bit is 0, `wdt_rst_n` stays high.
- R7: With control bit 3 set, one step takes 60 × CLKS_PER_SEC cycles.
- R8: Writing status bit 4 as 0 clears the flag. Writing it as 1 leaves the flag unchanged. If an expiry and a clear fall on the same edge, the flag ends up set.
- R9: Status bits 7 and 6 are stored and read back as written, and have no effect on counting. All other status bits except bit 4 read 0.
- R10: A timeout write on the same cycle as a prescaler step loads the written value, with no decrement applied.
- R11: The control register reads back all 8 bits as written. Select 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select: 0 timeout, 1 control, 2 status, 3 reserved |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| wdt_rst_n | output | 1 | Active-low expiry reset pulse |

## Verification
The bench runs the whole path to expiry for every timeout from 1 to 40 and for 255. At each one it checks the cycle before expiry and the expiry cycle itself. An off-by-one in the prescaler or the counter would move expiry by a whole step. A reload that fails to restart the prescaler would fire early after a kick.

A write placed on the step cycle catches a decrement that wins over the load: the readback would show the value minus one. An expiry on the same edge as a status clear catches a clear that wins: the flag would read 0. The bench also times the reset pulse edge to edge and runs a minute-mode expiry, which catches a stretcher that is too long or short and a minute divider that is off by one second.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int unsigned REG_W        = 8;
   localparam int unsigned SECS_PER_MIN = 60;

   typedef enum logic [1:0] {
      SEL_TIMEOUT = 2'd0,
      SEL_CTRL    = 2'd1,
      SEL_STATUS  = 2'd2,
      SEL_RSVD    = 2'd3
   } wdt_sel_e;

   // control register bit positions
   localparam int unsigned CTRL_PULSE_EN = 1;
   localparam int unsigned CTRL_MINUTES  = 3;

   // status register bit positions
   localparam int unsigned STAT_FIRED    = 4;
   localparam int unsigned STAT_KBD_EN   = 6;
   localparam int unsigned STAT_MOUSE_EN = 7;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned CLKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic minutes,
   output logic unit_tick
);
   import wdt_pkg::*;

   localparam int unsigned SUB_W = $clog2(CLKS_PER_SEC);
   localparam int unsigned MIN_W = $clog2(SECS_PER_MIN);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLKS_PER_SEC - 1);
   localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(SECS_PER_MIN - 1);

   if (CLKS_PER_SEC < 2) begin : g_bad_rate
      $error("wdt_prescaler: CLKS_PER_SEC must be at least 2");
   end

   logic [SUB_W-1:0] sub_q;
   logic [MIN_W-1:0] sec_q;
   logic             sec_tick;

   assign sec_tick = (sub_q == SUB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
      end else if (restart || sec_tick) begin
         sub_q <= '0;
      end else begin
         sub_q <= sub_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
      end else if (restart) begin
         sec_q <= '0;
      end else if (sec_tick) begin
         sec_q <= (sec_q == MIN_LAST) ? '0 : sec_q + 1'b1;
      end
   end

   assign unit_tick = minutes ? (sec_tick && (sec_q == MIN_LAST)) : sec_tick;

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   if (CNT_W < 2) begin : g_bad_width
      $error("wdt_downcount: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign count  = cnt_q;
   assign expire = tick && !load && (cnt_q == LAST_ONE);

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int unsigned PULSE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic out_n
);

   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("wdt_pulse: PULSE_CYCLES must be at least 1");
   end

   if (PULSE_CYCLES == 1) begin : g_single
      logic low_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) low_q <= 1'b0;
         else        low_q <= fire;
      end
      assign out_n = ~low_q;
   end else begin : g_stretch
      localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
      localparam logic [PW-1:0] PLEN = PW'(PULSE_CYCLES);
      logic [PW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            left_q <= '0;
         end else if (fire) begin
            left_q <= PLEN;
         end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
         end
      end
      assign out_n = (left_q == '0);
   end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
   import wdt_pkg::*;
#(
   parameter int unsigned CLKS_PER_SEC = 32768,
   parameter int unsigned PULSE_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             wdt_rst_n
);

   logic             wr_timeout, wr_ctrl, wr_status;
   logic [REG_W-1:0] ctrl_q;
   logic             fired_q, kbd_en_q, mouse_en_q;
   logic             unit_tick, expire, fire;
   logic [REG_W-1:0] count_q;

   assign wr_timeout = reg_wr && (reg_sel == SEL_TIMEOUT);
   assign wr_ctrl    = reg_wr && (reg_sel == SEL_CTRL);
   assign wr_status  = reg_wr && (reg_sel == SEL_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q    <= 1'b0;
         kbd_en_q   <= 1'b0;
         mouse_en_q <= 1'b0;
      end else begin
         if (expire) begin
            fired_q <= 1'b1;
         end else if (wr_status && !reg_wdata[STAT_FIRED]) begin
            fired_q <= 1'b0;
         end
         if (wr_status) begin
            kbd_en_q   <= reg_wdata[STAT_KBD_EN];
            mouse_en_q <= reg_wdata[STAT_MOUSE_EN];
         end
      end
   end

   wdt_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (wr_timeout),
      .minutes   (ctrl_q[CTRL_MINUTES]),
      .unit_tick (unit_tick)
   );

   wdt_downcount #(.CNT_W(REG_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_timeout),
      .load_val (reg_wdata),
      .tick     (unit_tick),
      .count    (count_q),
      .expire   (expire)
   );

   assign fire = expire && ctrl_q[CTRL_PULSE_EN];

   wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .out_n (wdt_rst_n)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_TIMEOUT: reg_rdata = count_q;
         SEL_CTRL:    reg_rdata = ctrl_q;
         SEL_STATUS: begin
            reg_rdata[STAT_FIRED]    = fired_q;
            reg_rdata[STAT_KBD_EN]   = kbd_en_q;
            reg_rdata[STAT_MOUSE_EN] = mouse_en_q;
         end
         default:     reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
   parameter int unsigned PULSE_CYCLES = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [1:0] reg_sel,
   input logic [7:0] reg_wdata,
   input logic [7:0] count,
   input logic       fired,
   input logic       pulse_en,
   input logic       fire,
   input logic       wdt_rst_n
);

   localparam int unsigned LW = $clog2(PULSE_CYCLES + 2) + 1;
   localparam logic [LW-1:0] LMAX = '1;
   localparam logic [LW-1:0] LLIM = LW'(PULSE_CYCLES);

   logic          wr_to;
   logic [LW-1:0] low_run;

   assign wr_to = reg_wr && (reg_sel == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               low_run <= '0;
      else if (fire)            low_run <= LW'(1);
      else if (!wdt_rst_n)      low_run <= (low_run == LMAX) ? LMAX : low_run + 1'b1;
      else                      low_run <= '0;
   end

   AST_LOAD_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_to |=> (count == $past(reg_wdata)));                               // R10

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_to |=> ((count == $past(count)) || (count == $past(count) - 8'd1))); // R2

   AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_to && (count == 8'd0)) |=> (count == 8'd0));                     // R3

   AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_to && (count == 8'd1)) |=> ((count != 8'd0) || fired));         // R5

   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !wdt_rst_n |-> (low_run <= LLIM));                                   // R6

   AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst_n) |-> $past(pulse_en));                               // R6

endmodule

bind wdt_timer wdt_timer_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .count     (count_q),
   .fired     (fired_q),
   .pulse_en  (ctrl_q[1]),
   .fire      (fire),
   .wdt_rst_n (wdt_rst_n)
);

// File: tb/wdt_timer_test.sv
module wdt_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam int P          = 4;   // clocks per second
   localparam int PULSE      = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       wdt_rst_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_timer #(.CLKS_PER_SEC(P), .PULSE_CYCLES(PULSE)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .wdt_rst_n (wdt_rst_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output int v);
      reg_sel = sel;
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int v;
      bit low_seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(2'd0, v); chk("R1 count", v, 0);
      rd(2'd1, v); chk("R1 ctrl", v, 0);
      rd(2'd2, v); chk("R1 status", v, 0);
      chk("R1 rst_out", int'(wdt_rst_n), 1);
      rst_n = 1'b1;
      step(2);

      // R11 control readback and reserved select
      wr(2'd1, 8'hA5); rd(2'd1, v); chk("R11 ctrl readback", v, 8'hA5);
      wr(2'd3, 8'hFF); rd(2'd1, v); chk("R11 rsvd write ignored", v, 8'hA5);
      rd(2'd3, v); chk("R11 rsvd reads 0", v, 0);

      // R2 R5 R6 sweep of timeouts
      for (int n = 1; n <= 41; n++) begin
         int t;
         t = (n == 41) ? 255 : n;
         wr(2'd2, 8'h00);
         wr(2'd1, 8'h02);
         wr(2'd0, 8'(t));
         rd(2'd0, v); chk("R2 load readback", v, t);
         step(t * P - 1);
         rd(2'd0, v); chk("R2 count before expiry", v, 1);
         rd(2'd2, v); chk("R5 no flag before expiry", v, 0);
         chk("R6 high before expiry", int'(wdt_rst_n), 1);
         step(1);
         rd(2'd0, v); chk("R5 count at expiry", v, 0);
         rd(2'd2, v); chk("R5 flag at expiry", v, 8'h10);
         chk("R6 low at expiry", int'(wdt_rst_n), 0);
         step(PULSE - 1);
         chk("R6 low last cycle", int'(wdt_rst_n), 0);
         step(1);
         chk("R6 high after pulse", int'(wdt_rst_n), 1);
         step(5);
         rd(2'd0, v); chk("R5 count holds 0", v, 0);
      end

      // R6 pulse disabled
      wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'd2);
      low_seen = 1'b0;
      for (int i = 0; i < 3 * P; i++) begin
         step(1);
         if (!wdt_rst_n) low_seen = 1'b1;
      end
      chk("R6 no pulse when disabled", int'(low_seen), 0);
      rd(2'd2, v); chk("R5 flag without pulse", v, 8'h10);

      // R3 stop
      wr(2'd2, 8'h00); wr(2'd1, 8'h02); wr(2'd0, 8'd5);
      step(6);
      rd(2'd0, v); chk("R2 mid count", v, 4);
      wr(2'd0, 8'd0);
      low_seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         step(1);
         if (!wdt_rst_n) low_seen = 1'b1;
      end
      rd(2'd0, v); chk("R3 stopped count", v, 0);
      rd(2'd2, v); chk("R3 no flag", v, 0);
      chk("R3 no pulse", int'(low_seen), 0);

      // R4 kick
      wr(2'd0, 8'd3); step(10);
      rd(2'd0, v); chk("R4 before kick", v, 1);
      wr(2'd0, 8'd3);
      rd(2'd0, v); chk("R4 reload", v, 3);
      step(11);
      rd(2'd0, v); chk("R4 full period after kick", v, 1);
      rd(2'd2, v); chk("R4 no early flag", v, 0);
      step(1);
      rd(2'd0, v); chk("R4 expiry after kick", v, 0);

      // R10 write on tick cycle
      wr(2'd2, 8'h00); wr(2'd0, 8'd9); step(P - 1);
      wr(2'd0, 8'd6);
      rd(2'd0, v); chk("R10 write beats tick", v, 6);
      step(P);
      rd(2'd0, v); chk("R10 next step", v, 5);
      wr(2'd0, 8'd0);

      // R8 R9 status
      wr(2'd0, 8'd1); step(P);
      rd(2'd2, v); chk("R8 flag set", v, 8'h10);
      wr(2'd2, 8'h10); rd(2'd2, v); chk("R8 write 1 keeps", v, 8'h10);
      wr(2'd2, 8'hFF); rd(2'd2, v); chk("R9 enable bits stored", v, 8'hD0);
      wr(2'd2, 8'hC0); rd(2'd2, v); chk("R8 write 0 clears", v, 8'hC0);
      wr(2'd0, 8'd1); step(P - 1);
      wr(2'd2, 8'hC0);
      rd(2'd2, v); chk("R8 expiry beats clear", v, 8'hD0);
      wr(2'd2, 8'hC0); wr(2'd0, 8'd2); step(2 * P - 1);
      rd(2'd0, v); chk("R9 enables do not alter count", v, 1);
      step(1);
      rd(2'd2, v); chk("R9 expiry with enables", v, 8'hD0);

      // R7 minute unit
      wr(2'd2, 8'h00); wr(2'd1, 8'h0A); wr(2'd0, 8'd2);
      step(60 * P - 1);
      rd(2'd0, v); chk("R7 before first minute", v, 2);
      step(1);
      rd(2'd0, v); chk("R7 first minute", v, 1);
      step(60 * P - 1);
      rd(2'd0, v); chk("R7 before second minute", v, 1);
      step(1);
      rd(2'd0, v); chk("R7 expiry", v, 0);
      chk("R7 pulse", int'(wdt_rst_n), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule